// File: doc/BRIEF.md
# Buffered Serial Burst Output Port

This block is the output stage of a multi-channel acquisition chain. Filtered channel samples arrive one at a time. The block packs them into a 256-byte buffer memory until a full block of sample sets has been gathered. By default a block is 42 sets of 3 channels, which is 420 ms of data at 100 sets per second. The block then raises an interrupt for a fixed lead time and sends the whole block to the host, MSB first, on a serial clock and data pair. Sending takes a few percent of the time needed to fill a block.

Each sample can be stored as one byte or as two bytes. A mode input selects this per block, and the choice is taken when the first sample of a block is written. The memory is used as a ring. The next block fills the bytes that follow the block being sent, and a guard stops the writer from overwriting bytes that have not been sent yet. A block cannot be sent in two cases: it completes while a burst is still running, or its bytes would overwrite unsent bytes. Such a block is discarded, and a sticky overflow flag is raised.

Top module: `ser_burst_out`

## Requirements
- R1: After reset, `irq`, `sclk`, `sdata` and `ovf` are all low.
- R2: A block is NUM_CH x SETS_PER_BLK samples. With the defaults it is 126 bytes in byte mode and 252 bytes in word mode, and every accepted block produces exactly that many bytes on the serial output.
- R3: In byte mode (`mode16`=0) the stored byte is `smp_data[15:8]`. In word mode (`mode16`=1) the bytes `smp_data[15:8]` and then `smp_data[7:0]` are stored. Bytes are sent in arrival order, each with its bit 7 first.
- R4: The value of `mode16` at the first sample of a block sets the mode of the whole block. Changes to `mode16` later in that block have no effect on it.
- R5: After a block is accepted, `irq` goes high for exactly LEAD_SCLK x 2 x SCLK_HALF clock cycles. During that time `sclk` and `sdata` stay low. `irq` falls in the cycle in which the first bit is driven.
- R6: During a burst, each bit takes SCLK_HALF cycles with `sclk` low followed by SCLK_HALF cycles with `sclk` high, so consecutive rising edges are 2 x SCLK_HALF cycles apart. `sdata` changes only when `sclk` falls or as the burst starts, and it holds steady while `sclk` is high. Between bursts `sclk` and `sdata` are low.
- R7: Samples keep being stored while a burst is in progress. A block that completes after the running burst has ended is sent normally, and its content is intact.
- R8: A block that completes while a burst is still in progress, or whose bytes would reach unsent bytes in the ring, is dropped. It produces no interrupt and no serial bytes, and `ovf` goes high and stays high until reset.
- R9: In byte mode a sample is accepted on every clock cycle. In word mode there must be at least one idle cycle between samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode16 | input | 1 | Sample width select: 1 = two bytes per sample, 0 = one byte |
| smp_valid | input | 1 | Sample strobe, one cycle per channel sample |
| smp_data | input | 16 | Channel sample value |
| irq | output | 1 | Burst announcement, high during the lead time before the first bit |
| sclk | output | 1 | Serial clock to the host, low when idle |
| sdata | output | 1 | Serial data, valid at the rising edge of `sclk` |
| ovf | output | 1 | Sticky flag: a block was dropped |

## Verification
Filling and draining share the buffer memory, so a sample write and a byte fetch for the serial shifter can fall in the same cycle. A block completion can also coincide with a burst that is still running. The bench provokes the first case by feeding a block slowly, spread over the whole burst of the previous block: every byte of both blocks must come out intact and in order. It provokes the second case by feeding a second block at full speed right behind the first: only the first block's bytes may appear, and `ovf` must rise and stay set while a later block is still sent normally.

// File: rtl/sbo_pkg.sv
`timescale 1ns/1ps
package sbo_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_LEAD = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;

  // Bytes in one block for the chosen sample width.
  function automatic int blk_bytes(input int nch, input int sets, input logic wide);
    return nch * sets * (wide ? 2 : 1);
  endfunction

  // Clock cycles the announcement lasts before the first bit.
  function automatic int lead_cycles(input int lead_sclk, input int half);
    return lead_sclk * 2 * half;
  endfunction

endpackage

// File: rtl/sbo_ram.sv
`timescale 1ns/1ps
module sbo_ram #(
  parameter int MEM_DEPTH = 256
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [$clog2(MEM_DEPTH)-1:0] waddr,
  input  logic [7:0]                   wdata,
  input  logic                         re,
  input  logic [$clog2(MEM_DEPTH)-1:0] raddr,
  output logic [7:0]                   rdata
);

  logic [7:0] store [MEM_DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
    if (re) begin
      rdata <= store[raddr];
    end
  end

endmodule

// File: rtl/sbo_fill.sv
`timescale 1ns/1ps
module sbo_fill #(
  parameter int NUM_CH       = 3,
  parameter int SETS_PER_BLK = 42,
  parameter int MEM_DEPTH    = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mode16,
  input  logic                         smp_valid,
  input  logic [15:0]                  smp_data,
  input  logic                         tx_busy,
  input  logic [$clog2(MEM_DEPTH):0]   tx_unread,
  output logic                         mem_we,
  output logic [$clog2(MEM_DEPTH)-1:0] mem_waddr,
  output logic [7:0]                   mem_wdata,
  output logic                         blk_commit,
  output logic                         blk_drop,
  output logic [$clog2(MEM_DEPTH)-1:0] blk_base,
  output logic [$clog2(MEM_DEPTH):0]   blk_len
);

  localparam int AW    = $clog2(MEM_DEPTH);
  localparam int CW    = AW + 1;
  localparam int LEN8  = sbo_pkg::blk_bytes(NUM_CH, SETS_PER_BLK, 1'b0);
  localparam int LEN16 = sbo_pkg::blk_bytes(NUM_CH, SETS_PER_BLK, 1'b1);

  logic [CW-1:0] fill_cnt;
  logic          blk_wide;
  logic          lo_pend;
  logic [7:0]    lo_byte;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] base_ptr;
  logic          poison;

  // Named internal events
  logic          cur_wide;
  logic          byte_we;
  logic [7:0]    byte_val;
  logic [CW-1:0] cur_len;
  logic [CW:0]   occupancy;
  logic          room_hit;
  logic          poison_n;
  logic          last_byte;
  logic          drop_now;
  logic          first_byte;
  logic [AW-1:0] start_ptr;

  always_comb begin
    first_byte = (fill_cnt == '0) && !lo_pend;
    cur_wide   = first_byte ? mode16 : blk_wide;
    byte_we    = lo_pend || smp_valid;
    byte_val   = lo_pend ? lo_byte : smp_data[15:8];
    cur_len    = cur_wide ? CW'(LEN16) : CW'(LEN8);
    occupancy  = {1'b0, fill_cnt} + {1'b0, tx_unread};
    room_hit   = byte_we && (occupancy >= (CW+1)'(MEM_DEPTH));
    poison_n   = poison || room_hit;
    last_byte  = byte_we && ((fill_cnt + CW'(1)) == cur_len);
    drop_now   = last_byte && (poison_n || tx_busy);
    start_ptr  = first_byte ? wr_ptr : base_ptr;
  end

  assign mem_we    = byte_we && !poison_n;
  assign mem_waddr = wr_ptr;
  assign mem_wdata = byte_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt   <= '0;
      blk_wide   <= 1'b0;
      lo_pend    <= 1'b0;
      lo_byte    <= '0;
      wr_ptr     <= '0;
      base_ptr   <= '0;
      poison     <= 1'b0;
      blk_commit <= 1'b0;
      blk_drop   <= 1'b0;
      blk_base   <= '0;
      blk_len    <= '0;
    end else begin
      blk_commit <= last_byte && !drop_now;
      blk_drop   <= drop_now;
      if (last_byte) begin
        blk_base <= start_ptr;
        blk_len  <= cur_len;
      end
      if (byte_we) begin
        if (first_byte) begin
          blk_wide <= mode16;
          base_ptr <= wr_ptr;
        end
        if (lo_pend) begin
          lo_pend <= 1'b0;
        end else begin
          lo_pend <= cur_wide;
          lo_byte <= smp_data[7:0];
        end
        if (last_byte) begin
          fill_cnt <= '0;
          poison   <= 1'b0;
          wr_ptr   <= drop_now ? start_ptr : wr_ptr + AW'(1);
        end else begin
          fill_cnt <= fill_cnt + CW'(1);
          poison   <= poison_n;
          wr_ptr   <= wr_ptr + AW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sbo_tx.sv
`timescale 1ns/1ps
module sbo_tx #(
  parameter int MEM_DEPTH = 256,
  parameter int SCLK_HALF = 2,
  parameter int LEAD_SCLK = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         blk_commit,
  input  logic [$clog2(MEM_DEPTH)-1:0] blk_base,
  input  logic [$clog2(MEM_DEPTH):0]   blk_len,
  input  logic [7:0]                   rd_q,
  output logic                         rd_en,
  output logic [$clog2(MEM_DEPTH)-1:0] rd_addr,
  output logic                         sclk,
  output logic                         sdata,
  output logic                         irq,
  output logic                         busy,
  output logic [$clog2(MEM_DEPTH):0]   unread
);

  import sbo_pkg::*;

  localparam int AW    = $clog2(MEM_DEPTH);
  localparam int CW    = AW + 1;
  localparam int BITC  = 2 * SCLK_HALF;
  localparam int LEADC = lead_cycles(LEAD_SCLK, SCLK_HALF);
  localparam int PW    = (BITC > 1) ? $clog2(BITC) : 1;
  localparam int LW    = (LEADC > 1) ? $clog2(LEADC) : 1;

  tx_state_e     st;
  logic [LW-1:0] lead_cnt;
  logic [PW-1:0] ph;
  logic [2:0]    bitn;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] remain;
  logic [7:0]    shreg;

  // Named internal events
  logic lead_end;
  logic bit_end;
  logic byte_end;
  logic prefetch;

  always_comb begin
    lead_end = (st == TX_LEAD) && (lead_cnt == LW'(LEADC - 1));
    bit_end  = (st == TX_SEND) && (ph == PW'(BITC - 1));
    byte_end = bit_end && (bitn == 3'd7);
    prefetch = ((st == TX_LEAD) && (lead_cnt == LW'(LEADC - 2))) ||
               ((st == TX_SEND) && (bitn == 3'd7) && (ph == PW'(BITC - 2)) &&
                (remain > CW'(1)));
  end

  assign rd_en   = prefetch;
  assign rd_addr = rd_ptr;
  assign sclk    = (st == TX_SEND) && (ph >= PW'(SCLK_HALF));
  assign sdata   = (st == TX_SEND) && shreg[7];
  assign irq     = (st == TX_LEAD);
  assign busy    = (st != TX_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= TX_IDLE;
      lead_cnt <= '0;
      ph       <= '0;
      bitn     <= '0;
      rd_ptr   <= '0;
      unread   <= '0;
      remain   <= '0;
      shreg    <= '0;
    end else begin
      if (prefetch) begin
        rd_ptr <= rd_ptr + AW'(1);
        unread <= unread - CW'(1);
      end
      unique case (st)
        TX_IDLE: begin
          if (blk_commit) begin
            st       <= TX_LEAD;
            lead_cnt <= '0;
            rd_ptr   <= blk_base;
            unread   <= blk_len;
            remain   <= blk_len;
          end
        end
        TX_LEAD: begin
          lead_cnt <= lead_cnt + LW'(1);
          if (lead_end) begin
            st    <= TX_SEND;
            ph    <= '0;
            bitn  <= '0;
            shreg <= rd_q;
          end
        end
        TX_SEND: begin
          ph <= bit_end ? '0 : ph + PW'(1);
          if (bit_end) begin
            bitn <= bitn + 3'd1;
            if (byte_end) begin
              remain <= remain - CW'(1);
              if (remain == CW'(1)) begin
                st <= TX_IDLE;
              end else begin
                shreg <= rd_q;
              end
            end else begin
              shreg <= {shreg[6:0], 1'b0};
            end
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ser_burst_out.sv
`timescale 1ns/1ps
module ser_burst_out #(
  parameter int NUM_CH       = 3,
  parameter int SETS_PER_BLK = 42,
  parameter int MEM_DEPTH    = 256,
  parameter int SCLK_HALF    = 2,
  parameter int LEAD_SCLK    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode16,
  input  logic        smp_valid,
  input  logic [15:0] smp_data,
  output logic        irq,
  output logic        sclk,
  output logic        sdata,
  output logic        ovf
);

  localparam int AW = $clog2(MEM_DEPTH);
  localparam int CW = AW + 1;

  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_q;
  logic          blk_commit;
  logic          blk_drop;
  logic [AW-1:0] blk_base;
  logic [CW-1:0] blk_len;
  logic          tx_busy;
  logic [CW-1:0] tx_unread;
  logic          ovf_q;

  sbo_fill #(
    .NUM_CH      (NUM_CH),
    .SETS_PER_BLK(SETS_PER_BLK),
    .MEM_DEPTH   (MEM_DEPTH)
  ) u_fill (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode16    (mode16),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .tx_busy   (tx_busy),
    .tx_unread (tx_unread),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .blk_commit(blk_commit),
    .blk_drop  (blk_drop),
    .blk_base  (blk_base),
    .blk_len   (blk_len)
  );

  sbo_ram #(
    .MEM_DEPTH(MEM_DEPTH)
  ) u_ram (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .re   (rd_en),
    .raddr(rd_addr),
    .rdata(rd_q)
  );

  sbo_tx #(
    .MEM_DEPTH(MEM_DEPTH),
    .SCLK_HALF(SCLK_HALF),
    .LEAD_SCLK(LEAD_SCLK)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_commit(blk_commit),
    .blk_base  (blk_base),
    .blk_len   (blk_len),
    .rd_q      (rd_q),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .sclk      (sclk),
    .sdata     (sdata),
    .irq       (irq),
    .busy      (tx_busy),
    .unread    (tx_unread)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else if (blk_drop) begin
      ovf_q <= 1'b1;
    end
  end

  assign ovf = ovf_q;

endmodule

// File: rtl/sbo_checker.sv
`timescale 1ns/1ps
module sbo_checker (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic sclk,
  input logic sdata,
  input logic ovf,
  input logic blk_commit,
  input logic blk_drop,
  input logic tx_busy
);

  AST_IRQ_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(blk_commit)); // R5

  AST_LEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!sclk && !sdata)); // R5

  AST_SDATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> (!sclk && !sdata && !irq)); // R6

  AST_COMMIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_commit |-> !tx_busy); // R8

  AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    blk_drop |=> ovf); // R8

  AST_DROP_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    blk_drop |=> !$rose(irq)); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R8

endmodule

bind ser_burst_out sbo_checker u_sbo_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .sclk      (sclk),
  .sdata     (sdata),
  .ovf       (ovf),
  .blk_commit(blk_commit),
  .blk_drop  (blk_drop),
  .tx_busy   (tx_busy)
);

// File: tb/test_ser_burst_out.sv
`timescale 1ns/1ps
module test_ser_burst_out;

  localparam int NCH   = 3;
  localparam int SETS  = 42;
  localparam int HALF  = 2;
  localparam int LEADS = 4;
  localparam int NSMP  = NCH * SETS;        // samples per block
  localparam int LEAD_CYC = LEADS * HALF * 2; // announcement length in cycles

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode16 = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        irq, sclk, sdata, ovf;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  ser_burst_out i_ser_burst_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode16   (mode16),
    .smp_valid(smp_valid),
    .smp_data (smp_data),
    .irq      (irq),
    .sclk     (sclk),
    .sdata    (sdata),
    .ovf      (ovf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- monitor / scoreboard ----------------
  int   cyc = 0;
  int   irq_cnt = 0;
  int   last_rise = -1;
  int   nbits = 0;
  int   burst_bytes = 0;
  logic prev_sclk = 1'b0;
  logic prev_sdata = 1'b0;
  logic prev_irq = 1'b0;
  logic [7:0] shbuf = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (irq && !prev_irq) begin
        burst_bytes = 0;
        last_rise = -1;
        nbits = 0;
      end
      if (irq) begin
        irq_cnt++;
        if (sclk || sdata) chk(1'b0, "R5 lines quiet during announcement", {sclk, sdata}, 0);
      end
      if (prev_irq && !irq) begin
        chk(irq_cnt == LEAD_CYC, "R5 announcement length", irq_cnt, LEAD_CYC);
        irq_cnt = 0;
      end
      if (sclk && prev_sclk && (sdata != prev_sdata))
        chk(1'b0, "R6 sdata moved while sclk high", sdata, prev_sdata);
      if (!sclk && !prev_sclk && !irq && !prev_irq && (sdata != prev_sdata))
        chk(1'b0, "R6 sdata moved inside low phase", sdata, prev_sdata);
      if (sclk && !prev_sclk) begin
        if (last_rise >= 0 && (cyc - last_rise) != 2 * HALF)
          chk(1'b0, "R6 serial clock period", cyc - last_rise, 2 * HALF);
        last_rise = cyc;
        shbuf = {shbuf[6:0], sdata};
        nbits++;
        if (nbits == 8) begin
          nbits = 0;
          burst_bytes++;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected byte (dropped block sent?)", shbuf, -1);
          end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(shbuf == e, "R3 serial byte value", shbuf, e);
          end
        end
      end
    end
    prev_sclk  = sclk;
    prev_sdata = sdata;
    prev_irq   = irq;
  end

  // ---------------- driver ----------------
  function automatic logic [15:0] smp_val(input int tag, input int i);
    logic [7:0] hi, lo;
    hi = 8'((tag * 29 + i) & 255);
    lo = 8'(((i * 7 + tag) & 255) ^ 8'h5A);
    return {hi, lo};
  endfunction

  // Feeds one block. The block's width is the mode at its first sample (R4).
  task automatic feed(input int tag, input int gap, input bit wide, input bit push,
                      input int sw_at, input bit sw_val);
    for (int i = 0; i < NSMP; i++) begin
      logic [15:0] v;
      v = smp_val(tag, i);
      @(negedge clk);
      if (i == 0) mode16 = wide;
      if (i == sw_at) mode16 = sw_val;
      smp_valid = 1'b1;
      smp_data  = v;
      if (push) begin
        exp_q.push_back(v[15:8]);
        if (wide) exp_q.push_back(v[7:0]);
      end
      if (gap > 0) begin
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic drain(input int exp_bytes, input string tag);
    wait (exp_q.size() == 0);
    repeat (40) @(negedge clk);
    chk(burst_bytes == exp_bytes, tag, burst_bytes, exp_bytes);
    chk(!irq && !sclk && !sdata, "R6 lines low between bursts", {irq, sclk, sdata}, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(irq == 1'b0,   "R1 irq after reset", irq, 0);
    chk(sclk == 1'b0,  "R1 sclk after reset", sclk, 0);
    chk(sdata == 1'b0, "R1 sdata after reset", sdata, 0);
    chk(ovf == 1'b0,   "R1 ovf after reset", ovf, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 R2 R3: byte mode, one sample per cycle
    feed(1, 0, 1'b0, 1'b1, -1, 1'b0);
    drain(NSMP, "R2 byte-mode block length");

    // R2 R3: word mode, high byte then low byte
    feed(2, 1, 1'b1, 1'b1, -1, 1'b0);
    drain(2 * NSMP, "R2 word-mode block length");

    // R4: mode raised mid-block is ignored for that block
    feed(3, 0, 1'b0, 1'b1, 5, 1'b1);
    drain(NSMP, "R4 mode held from first sample");

    // R4: mode dropped mid-block of a word block
    feed(4, 1, 1'b1, 1'b1, 7, 1'b0);
    drain(2 * NSMP, "R4 word mode held from first sample");

    // R7: next block fills slowly while the previous one is being sent
    mode16 = 1'b0;
    fork
      begin
        feed(5, 0, 1'b0, 1'b1, -1, 1'b0);
        feed(6, 39, 1'b0, 1'b1, -1, 1'b0);
      end
    join
    drain(NSMP, "R7 block filled during burst sent whole");
    chk(ovf == 1'b0, "R7 no overflow for late completion", ovf, 0);

    // R8: second block completes while the first is still being sent
    feed(7, 0, 1'b0, 1'b1, -1, 1'b0);
    chk(ovf == 1'b0, "R8 ovf low before drop", ovf, 0);
    feed(8, 0, 1'b0, 1'b0, -1, 1'b0);
    repeat (3) @(negedge clk);
    chk(ovf == 1'b1, "R8 ovf set on dropped block", ovf, 1);
    drain(NSMP, "R8 only the accepted block sent");

    // R8: later block still sent, flag sticky
    feed(9, 0, 1'b0, 1'b1, -1, 1'b0);
    drain(NSMP, "R8 block after overflow sent");
    chk(ovf == 1'b1, "R8 ovf sticky", ovf, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule